// File: doc/BRIEF.md
# Byte-Lane Static Memory Control Decoder

This block is a small on-chip memory with a control interface in the style of an asynchronous static RAM. The interface has two chip selects of opposite polarity, an active-low output enable, an active-low write enable and an active-low enable for each byte lane. The block turns these strobes into lane-wise write, read-drive and standby behaviour. The bidirectional data bus is split into a data-in vector, a data-out vector and one drive-enable flag per byte lane. An integration layer can build a real tri-state pin from these three signals.

The array holds 16-bit words. A strap input turns the block into a byte-wide memory with twice as many locations. In that mode an extra address bit picks one half of each word, and all traffic uses the lower lane only. Writes are taken on the rising clock edge. Read data is combinational from the addressed word. The array depth is a parameter, and the address bits above that depth are ignored.

Top module: `byte_lane_sram`

## Requirements
- R1: The block is selected only when `ce1N` is 0 and `ce2` is 1. In every other combination nothing is written and neither lane drives.
- R2: In word mode, when the block is selected and `weN` is 0, the next rising clock edge stores `dataIn[7:0]` into bits 7:0 of the addressed word if `bleN` is 0. On the same edge it stores `dataIn[15:8]` into bits 15:8 if `bheN` is 0. A lane whose enable is 1 keeps its old contents.
- R3: In word mode, when the block is selected, `oeN` is 0 and `weN` is 1, `driveLo` is 1 exactly when `bleN` is 0, and `driveHi` is 1 exactly when `bheN` is 0. A driven lane of `dataOut` carries the stored byte. An undriven lane reads 0.
- R4: Write has priority. While `weN` is 0, `driveLo` and `driveHi` are both 0, whatever the value of `oeN`.
- R5: Neither lane drives while `oeN` is 1. Neither lane drives while both lane enables are 1.
- R6: `standby` is 1 when the block is deselected. In word mode it is also 1 when `bleN` and `bheN` are both 1. In byte mode it is also 1 when `bleN` is 1.
- R7: With `byteMode` at 1, `bleN` is the only byte enable and `bheN` has no effect. `addrByte` at 0 selects bits 7:0 of the word and `addrByte` at 1 selects bits 15:8. Writes take `dataIn[7:0]`, reads appear on `dataOut[7:0]`, `driveHi` stays 0 and `dataOut[15:8]` reads 0.
- R8: Address bits at and above `DEPTH_W` are ignored. Two addresses that differ only in those bits reach the same word.
- R9: A word written on a clock edge shows on `dataOut` in the cycle that follows, with no extra read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Active-low reset; only gates the checks, the array is not cleared |
| byteMode | input | 1 | Strap: 1 selects byte-wide organisation |
| addr | input | ADDR_W (20) | Word address |
| addrByte | input | 1 | Half-word select, used in byte mode only |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| bheN | input | 1 | Upper lane enable, active low |
| bleN | input | 1 | Lower lane enable, active low |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data; undriven lanes read 0 |
| driveLo | output | 1 | Lower lane drives the bus |
| driveHi | output | 1 | Upper lane drives the bus |
| standby | output | 1 | Low-power state flag |

## Verification
The bench builds the block with `DEPTH_W` set to 4, so the array has 16 words. Full 20-bit random addresses then alias onto a few words, which exercises R8, and repeated partial-lane writes overwrite the same words often. The small depth also lets one pass of full-word writes define every location before any read. After that pass the bench steps through all 256 combinations of the six control strobes, the mode strap and the half select. It then runs a long random phase in which a behavioural model is compared with the design on every clock.

// File: rtl/byte_lane_sram_pkg.sv
package byte_lane_sram_pkg;
  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic wrLo;      // store into bits 7:0
    logic wrHi;      // store into bits 15:8
    logic drvLo;     // lower lane drives
    logic drvHi;     // upper lane drives
    logic swapLanes; // byte mode, upper half selected
  } laneStrobe_t;
endpackage

// File: rtl/byte_lane_sram_ctrl.sv
module byte_lane_sram_ctrl
  import byte_lane_sram_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byteMode,
  input  logic        addrByte,
  input  logic        ce1N,
  input  logic        ce2,
  input  logic        oeN,
  input  logic        weN,
  input  logic        bheN,
  input  logic        bleN,
  output laneStrobe_t strobe,
  output logic        standby
);
  logic selected;
  logic writing;
  logic reading;
  logic hiEnable;

  always_comb begin
    selected = !ce1N && ce2;
    writing  = selected && !weN;
    reading  = selected && !oeN && weN;
    // in byte mode the upper enable is ignored
    hiEnable = !byteMode && !bheN;
    strobe.swapLanes = byteMode && addrByte;
    if (byteMode) begin
      strobe.wrLo  = writing && !bleN && !addrByte;
      strobe.wrHi  = writing && !bleN && addrByte;
      strobe.drvLo = reading && !bleN;
      strobe.drvHi = 1'b0;
    end else begin
      strobe.wrLo  = writing && !bleN;
      strobe.wrHi  = writing && hiEnable;
      strobe.drvLo = reading && !bleN;
      strobe.drvHi = reading && hiEnable;
    end
    standby = !selected || (bleN && (byteMode || bheN));
  end

  // R4: write enable low forbids any drive
  p_write_blocks_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !weN |-> !strobe.drvLo && !strobe.drvHi);
  // R1: deselected means no write and no drive
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1N || !ce2) |-> !strobe.wrLo && !strobe.wrHi && !strobe.drvLo && !strobe.drvHi);
  // R5: output enable high means no drive
  p_oe_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oeN |-> !strobe.drvLo && !strobe.drvHi);
  // R7: byte mode never drives the upper lane
  p_byte_mode_hi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byteMode |-> !strobe.drvHi);
  // R6: a driving lane implies the block is not in standby
  p_drive_not_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.drvLo || strobe.drvHi) |-> !standby);
  // R2: at most one write lane in byte mode
  p_byte_single_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byteMode |-> $countones({strobe.wrLo, strobe.wrHi}) <= 1);
endmodule

// File: rtl/byte_lane_sram_dp.sv
module byte_lane_sram_dp
  import byte_lane_sram_pkg::*;
#(
  parameter int DEPTH_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] wordIdx,
  input  laneStrobe_t        strobe,
  input  logic [15:0]        dataIn,
  output logic [15:0]        dataOut
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [15:0] mem [DEPTH];
  logic [15:0] curWord;
  logic [7:0]  wrDataHi;

  // byte mode feeds the upper half from the lower lane
  assign wrDataHi = strobe.swapLanes ? dataIn[7:0] : dataIn[15:8];
  assign curWord  = mem[wordIdx];

  always_ff @(posedge clk) begin
    if (strobe.wrLo) mem[wordIdx][7:0]  <= dataIn[7:0];
    if (strobe.wrHi) mem[wordIdx][15:8] <= wrDataHi;
  end

  always_comb begin
    dataOut = '0;
    if (strobe.drvLo) dataOut[7:0]  = strobe.swapLanes ? curWord[15:8] : curWord[7:0];
    if (strobe.drvHi) dataOut[15:8] = curWord[15:8];
  end

  // R2: a lower-lane write lands in the array
  p_lo_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrLo |=> mem[$past(wordIdx)][7:0] == $past(dataIn[7:0]));
  // R2: an upper-lane write lands in the array
  p_hi_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrHi |=> mem[$past(wordIdx)][15:8] == $past(wrDataHi));
  // R3: an undriven lane reads zero
  p_idle_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.drvHi |-> dataOut[15:8] == 8'h00);
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import byte_lane_sram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DEPTH_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrByte,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              oeN,
  input  logic              weN,
  input  logic              bheN,
  input  logic              bleN,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              driveLo,
  output logic              driveHi,
  output logic              standby
);
  laneStrobe_t strobe;
  logic [ADDR_W-1:0] unusedAddr;

  // upper address bits are ignored
  assign unusedAddr = addr;

  byte_lane_sram_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteMode(byteMode), .addrByte(addrByte),
    .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN), .bheN(bheN), .bleN(bleN),
    .strobe(strobe), .standby(standby)
  );

  byte_lane_sram_dp #(.DEPTH_W(DEPTH_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .wordIdx(addr[DEPTH_W-1:0]), .strobe(strobe),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  assign driveLo = strobe.drvLo;
  assign driveHi = strobe.drvHi;
endmodule

// File: tb/tb_byte_lane_sram.sv
module tb_byte_lane_sram;
  localparam int ADDR_W  = 20;
  localparam int DEPTH_W = 4;
  localparam int DEPTH   = 1 << DEPTH_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byteMode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic addrByte = 1'b0;
  logic ce1N = 1'b1, ce2 = 1'b0, oeN = 1'b1, weN = 1'b1, bheN = 1'b1, bleN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic driveLo, driveHi, standby;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] model [DEPTH];

  always #2 clk = ~clk;

  byte_lane_sram #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) dut (
    .clk(clk), .rst_n(rst_n), .byteMode(byteMode), .addr(addr), .addrByte(addrByte),
    .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN), .bheN(bheN), .bleN(bleN),
    .dataIn(dataIn), .dataOut(dataOut), .driveLo(driveLo), .driveHi(driveHi),
    .standby(standby)
  );

  task automatic compareNow();
    logic sel, rd, expLo, expHi, expSb;
    logic [15:0] w, expData;
    int idx;
    idx = int'(addr[DEPTH_W-1:0]);
    w = model[idx];
    sel = !ce1N && ce2;
    rd = sel && !oeN && weN;
    expLo = rd && !bleN;
    expHi = rd && !byteMode && !bheN;
    expSb = !sel || (byteMode ? bleN : (bleN && bheN));
    expData = 16'h0000;
    if (expLo) expData[7:0] = (byteMode && addrByte) ? w[15:8] : w[7:0];
    if (expHi) expData[15:8] = w[15:8];
    compared++;
    if (driveLo !== expLo || driveHi !== expHi) begin
      mismatched++;
      $display("FAIL R1/R3/R4/R5/R7 drive: got lo=%b hi=%b expected lo=%b hi=%b",
               driveLo, driveHi, expLo, expHi);
    end
    compared++;
    if (standby !== expSb) begin
      mismatched++;
      $display("FAIL R6 standby: got %b expected %b", standby, expSb);
    end
    compared++;
    if (dataOut !== expData) begin
      mismatched++;
      $display("FAIL R3/R7/R8/R9 data: got %h expected %h", dataOut, expData);
    end
  endtask

  task automatic modelWrite();
    int idx;
    idx = int'(addr[DEPTH_W-1:0]);
    if (!ce1N && ce2 && !weN) begin
      if (byteMode) begin
        if (!bleN) begin
          if (addrByte) model[idx][15:8] = dataIn[7:0];
          else          model[idx][7:0]  = dataIn[7:0];
        end
      end else begin
        if (!bleN) model[idx][7:0]  = dataIn[7:0];
        if (!bheN) model[idx][15:8] = dataIn[15:8];
      end
    end
  endtask

  // inputs already set after a negedge; check, then let the edge write
  task automatic cycle();
    #1 compareNow();
    @(posedge clk);
    modelWrite();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // reset state: deselected, standby, no drive (R1, R6)
    #1 compareNow();
    rst_n = 1'b1;
    @(negedge clk);
    // define every word with full-word writes (R2)
    ce1N = 0; ce2 = 1; weN = 0; oeN = 1; bleN = 0; bheN = 0;
    for (int i = 0; i < DEPTH; i++) begin
      addr = ADDR_W'(i);
      dataIn = 16'(32'hA500 + i * 32'h0111);
      cycle();
    end
    // read back each word (R3, R9)
    weN = 1; oeN = 0;
    for (int i = 0; i < DEPTH; i++) begin
      addr = ADDR_W'(i);
      cycle();
    end
    // all 256 combinations of strobes, mode and half select (R1, R4, R5, R6, R7)
    for (int c = 0; c < 256; c++) begin
      {byteMode, addrByte, ce1N, ce2, oeN, weN, bheN, bleN} = 8'(c);
      addr = ADDR_W'($urandom);
      dataIn = 16'($urandom);
      cycle();
    end
    // partial-lane write then read-back of the same word (R2, R9)
    byteMode = 0; ce1N = 0; ce2 = 1; addr = 20'h00003;
    weN = 0; bleN = 0; bheN = 1; dataIn = 16'h1234; cycle();
    weN = 1; oeN = 0; bleN = 0; bheN = 0; cycle();
    weN = 0; bleN = 1; bheN = 0; dataIn = 16'hBEEF; cycle();
    weN = 1; bleN = 0; bheN = 0; cycle();
    // byte mode: upper half write, lower half read, upper half read (R7)
    byteMode = 1; weN = 0; bleN = 0; bheN = 0; addrByte = 1; dataIn = 16'hFF5A; cycle();
    weN = 1; oeN = 0; addrByte = 0; cycle();
    addrByte = 1; cycle();
    // aliasing: high address bits ignored (R8)
    byteMode = 0; weN = 0; addr = 20'hABC05; dataIn = 16'hC0DE; cycle();
    weN = 1; addr = 20'h00005; cycle();
    addr = 20'h7FFF5; cycle();
    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      byteMode = ($urandom % 4) == 0;
      addrByte = 1'($urandom);
      ce1N = ($urandom % 6) == 0;
      ce2  = ($urandom % 6) != 0;
      oeN  = 1'($urandom);
      weN  = 1'($urandom);
      bheN = 1'($urandom);
      bleN = 1'($urandom);
      addr = ADDR_W'($urandom);
      dataIn = 16'($urandom);
      cycle();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule